// File: doc/BRIEF.md
# Adjacent-Line and Stride Prefetcher

This block sits beside a second-level cache. It watches the demand misses the cache reports and sends speculative line-fill requests toward the memory side. Each miss carries a line address and a stream identifier. Two predictors look at every miss.

The pair predictor fills in the other half of an aligned two-line group. After a miss on an even line it requests the odd neighbour, but only once a shared confidence counter shows that such neighbours tend to be missed. The stride predictor keeps one table entry per stream. It learns the distance between successive misses of that stream and requests the line one stride ahead once the same distance has repeated. Strides may be negative. A prediction that leaves the 4 KiB page of the miss is thrown away.

Predictions go into a short queue that feeds a ready/valid request port. Every request is flagged as a hint that the memory side may drop. A full queue drops new predictions instead of slowing miss intake, and a line already waiting in the queue is not added again.

Top module: `line_prefetcher`

## Requirements
- R1: While reset is held and in the first cycle after it, `pf_valid` is low. The queue, the stride table and the pair confidence all start empty or at zero.
- R2: Pair confidence is a 2-bit saturating counter. An odd-line miss increments it if the line with bit 0 cleared equals the most recent even-line miss, and otherwise decrements it (floor 0). Even-line misses leave it unchanged. An even-line miss seen while the counter is 2 or more requests that line with bit 0 set.
- R3: The stride table has 16 entries selected by `miss_sid[3:0]`. A miss to an unused entry claims it (last line = miss line, stride 0, confidence 0) and predicts nothing. A nonzero delta equal to the stored stride increments the 2-bit confidence (saturating at 3). Any other nonzero delta replaces the stride and clears the confidence. Both cases store the miss line as the last line.
- R4: When the updated confidence is 2 or more, the stride predictor requests miss line + stride, where the stride is a two's-complement delta modulo 2^AW. Negative strides are predicted the same way as positive ones.
- R5: A miss whose delta is zero leaves the table entry unchanged and makes no stride request.
- R6: A page is 64 lines, identified by line address bits [AW-1:6]. A stride prediction whose page differs from the page of the miss is discarded.
- R7: Requests leave in arrival order through a 4-entry FIFO. A request appears on `pf_valid`/`pf_line` the cycle after the miss that created it. When one miss creates both kinds, the pair request is queued ahead of the stride request.
- R8: Room is judged on the occupancy at the start of the cycle, and predictions that do not fit are dropped. Miss intake has no back-pressure.
- R9: A prediction equal to a line held in the queue at the start of the cycle is not queued. A stride prediction equal to the same miss's pair prediction is not queued.
- R10: While `pf_valid` is high and `pf_ready` is low, `pf_valid` and `pf_line` hold. `pf_hint` is high with every request. An accepted request leaves the queue for good.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | Demand miss present this cycle |
| miss_line | input | AW | Line address of the miss |
| miss_sid | input | SIDW | Stream identifier of the miss |
| pf_valid | output | 1 | Prefetch request available |
| pf_ready | input | 1 | Memory side accepts the request |
| pf_line | output | AW | Line address to prefetch |
| pf_hint | output | 1 | Request may be dropped downstream |

## Verification
The hardest state to reach is a saturated queue that is also the target of predictions that are duplicates, page crossings or pair/stride collisions. Only then do the drop and dedupe rules start to interact. The stimulus reaches it by holding `pf_ready` low while several streams are trained to confidence with chosen deltas, including a downward walk that ends on a page edge. A long random phase follows, with streams confined to a small address window and `pf_ready` toggling. A bench model predicts every queued line and its order.

// File: rtl/line_prefetcher.sv
module line_prefetcher #(
  parameter int AW = 28,
  parameter int SIDW = 6,
  parameter int TBL_LOG2 = 4,
  parameter int QLOG2 = 2,
  parameter int PG_LOG2 = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            miss_valid,
  input  logic [AW-1:0]   miss_line,
  input  logic [SIDW-1:0] miss_sid,
  output logic            pf_valid,
  input  logic            pf_ready,
  output logic [AW-1:0]   pf_line,
  output logic            pf_hint
);
  localparam int TBL = 1 << TBL_LOG2;
  localparam int QD  = 1 << QLOG2;

  logic [AW-1:0]  t_last [TBL];
  logic [AW-1:0]  t_str  [TBL];
  logic [1:0]     t_conf [TBL];
  logic [TBL-1:0] t_vld;

  logic [AW-1:0]    q [QD];
  logic [QLOG2-1:0] head;
  logic [QLOG2:0]   cnt;

  logic [1:0]    pconf;
  logic [AW-1:0] last_even;
  logic          le_vld;

  wire [TBL_LOG2-1:0] idx   = miss_sid[TBL_LOG2-1:0];
  wire                hit   = t_vld[idx];
  wire [AW-1:0]       delta = miss_line - t_last[idx];
  wire                zero_d = (delta == '0);
  wire                match  = (delta == t_str[idx]);
  wire [1:0]          conf_nx = match ? ((t_conf[idx] == 2'd3) ? 2'd3 : t_conf[idx] + 2'd1) : 2'd0;
  wire [AW-1:0]       cand_s = miss_line + t_str[idx];
  wire                same_pg = (cand_s[AW-1:PG_LOG2] == miss_line[AW-1:PG_LOG2]);
  wire                want_s = miss_valid && hit && !zero_d && match && conf_nx[1] && same_pg;
  wire [AW-1:0]       cand_p = {miss_line[AW-1:1], 1'b1};
  wire                want_p = miss_valid && !miss_line[0] && pconf[1];

  logic hit_p, hit_s;
  always_comb begin
    hit_p = 1'b0;
    hit_s = 1'b0;
    for (int i = 0; i < QD; i++) begin
      if ((QLOG2+1)'(i) < cnt) begin
        if (q[head + QLOG2'(i)] == cand_p) hit_p = 1'b1;
        if (q[head + QLOG2'(i)] == cand_s) hit_s = 1'b1;
      end
    end
  end

  wire             push_p = want_p && !hit_p && (cnt < (QLOG2+1)'(QD));
  wire [QLOG2+1:0] occ    = {1'b0, cnt} + (QLOG2+2)'(push_p);
  wire             push_s = want_s && !hit_s && !(want_p && cand_s == cand_p) && (occ < (QLOG2+2)'(QD));
  wire             pop    = pf_valid && pf_ready;
  wire [QLOG2-1:0] tail   = head + cnt[QLOG2-1:0];

  assign pf_valid = (cnt != '0);
  assign pf_line  = q[head];
  assign pf_hint  = pf_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head   <= '0;
      cnt    <= '0;
      t_vld  <= '0;
      pconf  <= 2'd0;
      le_vld <= 1'b0;
    end else begin
      if (pop) head <= head + 1'b1;
      cnt <= cnt + (QLOG2+1)'(push_p) + (QLOG2+1)'(push_s) - (QLOG2+1)'(pop);
      if (miss_valid && !hit) t_vld[idx] <= 1'b1;
      if (miss_valid) begin
        if (!miss_line[0]) le_vld <= 1'b1;
        else if (le_vld && cand_p == {last_even[AW-1:1], 1'b1})
          pconf <= (pconf == 2'd3) ? 2'd3 : pconf + 2'd1;
        else
          pconf <= (pconf == 2'd0) ? 2'd0 : pconf - 2'd1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push_p) q[tail] <= cand_p;
    if (push_s) q[tail + QLOG2'(push_p)] <= cand_s;
    if (miss_valid && !miss_line[0]) last_even <= miss_line;
    if (miss_valid) begin
      if (!hit) begin
        t_last[idx] <= miss_line;
        t_str[idx]  <= '0;
        t_conf[idx] <= 2'd0;
      end else if (!zero_d) begin
        t_last[idx] <= miss_line;
        t_conf[idx] <= conf_nx;
        if (!match) t_str[idx] <= delta;
      end
    end
  end

  wire [QLOG2-1:0] nxt = head + 1'b1;

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_valid && !pf_ready) |=> (pf_valid && $stable(pf_line)));

  a_r8_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == (QLOG2+1)'(QD) && !pf_ready) |=> (cnt == (QLOG2+1)'(QD)));

  a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= (QLOG2+1)'(QD));

  a_r5_zero_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_valid && hit && zero_d) |=>
      (t_conf[$past(idx)] == $past(t_conf[idx]) && t_str[$past(idx)] == $past(t_str[idx])));

  a_r9_head_distinct: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt >= (QLOG2+1)'(2)) |-> (q[head] != q[nxt]));

  a_r2_pair_even: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_valid && miss_line[0]) |=> (pconf != 2'd0 || $past(pconf) <= 2'd1));
endmodule

// File: tb/line_prefetcher_bench.sv
`timescale 1ns/1ps
module line_prefetcher_bench;
  localparam int AW = 28;
  localparam int SW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic miss_valid = 1'b0;
  logic [AW-1:0] miss_line = '0;
  logic [SW-1:0] miss_sid = '0;
  logic pf_ready = 1'b0;
  logic pf_valid, pf_hint;
  logic [AW-1:0] pf_line;

  always #2.5 clk = ~clk;

  line_prefetcher u_line_prefetcher (
    .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_line(miss_line),
    .miss_sid(miss_sid), .pf_valid(pf_valid), .pf_ready(pf_ready),
    .pf_line(pf_line), .pf_hint(pf_hint));

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  string tag = "R1";

  logic [AW-1:0] m_last [16];
  logic [AW-1:0] m_str  [16];
  logic [1:0]    m_conf [16];
  bit            m_vld  [16];
  logic [1:0]    m_pc;
  logic [AW-1:0] m_le;
  bit            m_lev;
  logic [AW-1:0] mq [$];

  task automatic chk(input bit ok, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_out();
    bit ev;
    ev = (mq.size() != 0);
    chk(pf_valid === ev, AW'(pf_valid), AW'(ev));
    if (ev && pf_valid === 1'b1) begin
      chk(pf_line === mq[0], pf_line, mq[0]);
      chk(pf_hint === 1'b1, AW'(pf_hint), AW'(1));
    end
  endtask

  function automatic bit in_q(input logic [AW-1:0] ln);
    foreach (mq[i]) if (mq[i] == ln) return 1'b1;
    return 1'b0;
  endfunction

  task automatic model(input bit mv, input logic [AW-1:0] ln, input logic [SW-1:0] sd, input bit rdy);
    int ix;
    logic [AW-1:0] d, cs, cp;
    logic [1:0] cn;
    bit ws, wp, pp, ps, pop;
    int occ;
    ix = int'(sd[3:0]);
    d = ln - m_last[ix];
    cn = (d == m_str[ix]) ? ((m_conf[ix] == 2'd3) ? 2'd3 : m_conf[ix] + 2'd1) : 2'd0;
    cs = ln + m_str[ix];
    ws = mv && m_vld[ix] && d != '0 && d == m_str[ix] && cn >= 2'd2 && cs[AW-1:6] == ln[AW-1:6];
    cp = ln | AW'(1);
    wp = mv && !ln[0] && m_pc >= 2'd2;
    occ = mq.size();
    pp = wp && !in_q(cp) && occ < 4;
    ps = ws && !in_q(cs) && !(wp && cs == cp) && (occ + int'(pp)) < 4;
    pop = (mq.size() != 0) && rdy;
    if (mv) begin
      if (!m_vld[ix]) begin
        m_vld[ix] = 1'b1; m_last[ix] = ln; m_str[ix] = '0; m_conf[ix] = 2'd0;
      end else if (d != '0) begin
        if (d != m_str[ix]) m_str[ix] = d;
        m_conf[ix] = cn; m_last[ix] = ln;
      end
      if (!ln[0]) begin
        m_le = ln; m_lev = 1'b1;
      end else if (m_lev && (ln ^ AW'(1)) == m_le) m_pc = (m_pc == 2'd3) ? 2'd3 : m_pc + 2'd1;
      else m_pc = (m_pc == 2'd0) ? 2'd0 : m_pc - 2'd1;
    end
    if (pop) void'(mq.pop_front());
    if (pp) mq.push_back(cp);
    if (ps) mq.push_back(cs);
  endtask

  task automatic step(input bit mv, input logic [AW-1:0] ln, input logic [SW-1:0] sd, input bit rdy);
    check_out();
    miss_valid = mv; miss_line = ln; miss_sid = sd; pf_ready = rdy;
    model(mv, ln, sd, rdy);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drain();
    for (int i = 0; i < 8; i++) step(1'b0, '0, '0, 1'b1);
  endtask

  initial begin
    logic [AW-1:0] cur [4];
    logic [AW-1:0] str [4];
    logic [AW-1:0] pcur;
    void'($urandom(32'd11));
    for (int i = 0; i < 16; i++) begin
      m_vld[i] = 1'b0; m_last[i] = '0; m_str[i] = '0; m_conf[i] = 2'd0;
    end
    m_pc = 2'd0; m_lev = 1'b0; m_le = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    tag = "R1";
    chk(pf_valid === 1'b0, AW'(pf_valid), '0);
    rst_n = 1'b1;
    step(1'b0, '0, '0, 1'b0);

    tag = "R2";
    step(1'b1, 28'h100, 6'd8, 1'b1);
    step(1'b1, 28'h101, 6'd9, 1'b1);
    step(1'b1, 28'h102, 6'd10, 1'b1);
    step(1'b1, 28'h103, 6'd11, 1'b1);
    step(1'b1, 28'h204, 6'd12, 1'b1);
    chk(pf_valid === 1'b1 && pf_line === 28'h205, pf_line, 28'h205);
    step(1'b1, 28'h301, 6'd13, 1'b1);
    step(1'b1, 28'h303, 6'd13, 1'b1);
    drain();

    tag = "R3 R4";
    step(1'b1, 28'd1000, 6'd1, 1'b0);
    step(1'b1, 28'd1003, 6'd1, 1'b0);
    step(1'b1, 28'd1006, 6'd1, 1'b0);
    step(1'b1, 28'd1009, 6'd1, 1'b0);
    chk(pf_valid === 1'b1 && pf_line === 28'd1012, pf_line, 28'd1012);
    step(1'b1, 28'h1F0, 6'd2, 1'b0);
    step(1'b1, 28'h1EE, 6'd2, 1'b0);
    step(1'b1, 28'h1EC, 6'd2, 1'b0);
    step(1'b1, 28'h1EA, 6'd2, 1'b0);
    drain();

    tag = "R5";
    step(1'b1, 28'h1EA, 6'd2, 1'b0);
    step(1'b1, 28'h1EA, 6'd2, 1'b0);
    step(1'b1, 28'h1E8, 6'd2, 1'b0);
    chk(pf_valid === 1'b1 && pf_line === 28'h1E6, pf_line, 28'h1E6);
    drain();

    tag = "R6";
    step(1'b1, 28'h1C6, 6'd3, 1'b0);
    step(1'b1, 28'h1C4, 6'd3, 1'b0);
    step(1'b1, 28'h1C2, 6'd3, 1'b0);
    step(1'b1, 28'h1C0, 6'd3, 1'b0);
    chk(pf_valid === 1'b0, AW'(pf_valid), '0);
    drain();

    tag = "R9";
    step(1'b1, 28'd10, 6'd4, 1'b0);
    step(1'b1, 28'd20, 6'd4, 1'b0);
    step(1'b1, 28'd30, 6'd4, 1'b0);
    step(1'b1, 28'd40, 6'd4, 1'b0);
    step(1'b1, 28'd42, 6'd5, 1'b0);
    step(1'b1, 28'd44, 6'd5, 1'b0);
    step(1'b1, 28'd46, 6'd5, 1'b0);
    step(1'b1, 28'd48, 6'd5, 1'b0);
    drain();

    tag = "R7 R8";
    for (int s = 0; s < 6; s++)
      for (int k = 0; k < 4; k++)
        step(1'b1, AW'(4096 * (s + 1) + 5 * k), SW'(16 + s), 1'b0);
    chk(pf_valid === 1'b1 && pf_line === 28'h1000 + 28'd20, pf_line, 28'h1014);
    drain();

    tag = "R10";
    for (int i = 0; i < 4; i++) begin
      cur[i] = AW'($urandom % 4096); str[i] = AW'(1);
    end
    pcur = '0;
    for (int n = 0; n < 3000; n++) begin
      int s, r;
      logic [SW-1:0] sd;
      s = int'($urandom % 6);
      r = int'($urandom % 10);
      sd = {SW'($urandom % 4), 2'b00};
      if (s < 4) begin
        sd = sd | SW'(s);
        if (r == 0) begin
          int pick;
          logic [AW-1:0] opts [5];
          opts[0] = -AW'(3); opts[1] = -AW'(1); opts[2] = AW'(1); opts[3] = AW'(2); opts[4] = AW'(5);
          pick = int'($urandom % 5);
          cur[s] = AW'($urandom % 4096);
          str[s] = opts[pick];
        end else if (r != 1) cur[s] = (cur[s] + str[s]) & AW'(12'hFFF);
        step(1'b1, cur[s], sd, ($urandom % 10) < 6);
      end else if (s == 4) begin
        if (!pcur[0]) pcur = (r < 6) ? (pcur | AW'(1)) : (AW'($urandom % 4096) & ~AW'(1));
        else pcur = AW'($urandom % 4096) & ~AW'(1);
        step(1'b1, pcur, SW'(7), ($urandom % 10) < 6);
      end else
        step(1'b0, '0, '0, ($urandom % 10) < 6);
    end
    drain();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL %s watchdog expired actual=%h expected=%h", tag, 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule